// File: doc/BRIEF.md
# Interrupt Priority and Acknowledge Unit

This unit keeps the interrupt state of one processor core. Three bitmaps, one bit per vector, record which vectors are waiting for service, which are being serviced, and which were raised as level-triggered. An 8-bit task-priority register, written by the core, sets a floor. The unit combines that floor with the class of the most urgent in-service vector to give a processor-priority value. A vector's class is its upper four bits.

Request pulses come in from the interrupt fabric. Each pulse carries a vector and a level flag. The unit presents the most urgent pending vector to the core whenever that vector's class clears the processor priority. When the core acknowledges, the offered vector moves from pending to in-service. When the core writes end-of-interrupt, the most urgent in-service vector is retired. If that vector was level-triggered, the unit pulses a broadcast strobe carrying the vector, so the external controller can re-sample its line.

Vectors 0 to 15 are reserved. A request for one of them is refused: an error flag is latched and a programmable error vector is raised in its place. Only fixed and lowest-priority deliveries reach this unit.

Top module: `irq_prio_unit`

## Requirements
- R1: `ppr` equals the task priority when the task-priority class (bits 7:4) is at least the class of the highest in-service vector. Otherwise it equals that class in bits 7:4 with bits 3:0 zero. With nothing in service, the in-service class counts as 0, and `ppr` is 0 after reset.
- R2: A task-priority write stores bits 7:0 of `tpr_wdata` and discards the upper bits. The new value shows in `ppr` in the following cycle.
- R3: `irq_valid` is high exactly when the highest pending vector V satisfies (V AND 0xF0) > `ppr`, and the unit is enabled. `irq_vector` then equals V.
- R4: An `ack` while `irq_valid` is high clears the offered vector's pending bit, sets its in-service bit and recomputes `ppr`. An `ack` while `irq_valid` is low has no effect.
- R5: An `eoi_wr` clears the highest set in-service bit and recomputes `ppr`. With nothing in service it has no effect.
- R6: When the vector retired by an EOI has its level bit set, the unit clears that bit and raises `eoi_bcast` for one cycle, in the cycle after the EOI write, with `eoi_bcast_vec` set to the vector. Retiring an edge vector raises no strobe.
- R7: A request whose vector is already pending is dropped, together with its level flag. An accepted request with `req_level` high also sets the vector's level bit.
- R8: A request for a vector below 16 never becomes pending. It sets the sticky `err_illegal` flag and raises `err_vector` as an edge-triggered request instead, subject to R7.
- R9: While `enable` is low, requests change nothing and `irq_valid` stays low.
- R10: When `ack` and `eoi_wr` arrive in the same cycle, both take effect. The EOI retires the highest vector that was in service before the acknowledge.
- R11: A request or an acknowledge is visible on `irq_valid`, `irq_vector` and `ppr` in the first cycle after the clock edge that captured it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Unit enabled; when low, requests are ignored and nothing is offered |
| req_valid | input | 1 | Request pulse |
| req_vector | input | 8 | Requested vector |
| req_level | input | 1 | Request is level-triggered |
| err_vector | input | 8 | Vector raised in place of a reserved-vector request |
| ack | input | 1 | Core takes the offered vector |
| eoi_wr | input | 1 | End-of-interrupt write |
| tpr_wr | input | 1 | Task-priority write strobe |
| tpr_wdata | input | 32 | Task-priority write data (bits 7:0 kept) |
| irq_valid | output | 1 | A deliverable vector is offered |
| irq_vector | output | 8 | Offered vector |
| ppr | output | 8 | Processor priority |
| eoi_bcast | output | 1 | Level-triggered vector retired (one-cycle strobe) |
| eoi_bcast_vec | output | 8 | Vector of the retired level-triggered interrupt |
| err_illegal | output | 1 | Sticky flag: a reserved vector was requested |

## Verification
The assertions check the invariants that hold on every cycle:
- `ppr` never falls below the task priority, and has a zero low nibble whenever it differs from it.
- An offered vector is always pending and its class is above `ppr`.
- An acknowledge lands the vector in service, and an EOI clears the bit it targeted.
- Each broadcast strobe traces back to a real retirement.
- The error flag is sticky, and nothing moves while the unit is disabled.

Only the bench's scenarios can show ordering effects: which vector an EOI retires when an acknowledge arrives in the same cycle, that a duplicate request loses its level flag, and that a reserved vector is replaced by the error vector. These are checked against a behavioural model over directed and random traffic.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

  localparam int VEC_W = 8;
  localparam int CLS_W = 4;
  localparam int SUB_W = VEC_W - CLS_W;
  localparam int NVEC  = 1 << VEC_W;

  typedef logic [VEC_W-1:0] vec_t;
  typedef logic [CLS_W-1:0] cls_t;

  // Class of a vector: its upper bits.
  function automatic cls_t class_of(input vec_t v);
    return v[VEC_W-1 -: CLS_W];
  endfunction

  // Processor priority from task priority and highest in-service class.
  function automatic vec_t calc_ppr(input vec_t tpr, input cls_t isr_cls);
    if (class_of(tpr) >= isr_cls)
      return tpr;
    else
      return {isr_cls, {SUB_W{1'b0}}};
  endfunction

  // A vector is deliverable when its class, aligned, is strictly above ppr.
  function automatic logic above_floor(input vec_t v, input vec_t p);
    return {class_of(v), {SUB_W{1'b0}}} > p;
  endfunction

endpackage

// File: rtl/vec_find.sv
module vec_find #(
  parameter int N = 256,
  parameter int W = 8
) (
  input  logic [N-1:0] bits,
  output logic         found,
  output logic [W-1:0] idx
);

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = 0; i < N; i++) begin
      if (bits[i]) begin
        found = 1'b1;
        idx   = W'(i);
      end
    end
  end

endmodule

// File: rtl/vec_bitmap.sv
module vec_bitmap #(
  parameter int N = 256,
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_en,
  input  logic [W-1:0] set_idx,
  input  logic         clr_en,
  input  logic [W-1:0] clr_idx,
  output logic [N-1:0] q
);

  localparam logic [N-1:0] ONE = N'(1);

  logic [N-1:0] set_m, clr_m;

  assign set_m = set_en ? (ONE << set_idx) : '0;
  assign clr_m = clr_en ? (ONE << clr_idx) : '0;

  // a set and a clear of the same bit in one cycle leave it set
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= (q & ~clr_m) | set_m;
  end

endmodule

// File: rtl/irq_prio_unit.sv
module irq_prio_unit
  import irq_prio_pkg::*;
#(
  parameter int LEGAL_MIN = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             req_valid,
  input  logic [VEC_W-1:0] req_vector,
  input  logic             req_level,
  input  logic [VEC_W-1:0] err_vector,
  input  logic             ack,
  input  logic             eoi_wr,
  input  logic             tpr_wr,
  input  logic [31:0]      tpr_wdata,
  output logic             irq_valid,
  output logic [VEC_W-1:0] irq_vector,
  output logic [VEC_W-1:0] ppr,
  output logic             eoi_bcast,
  output logic [VEC_W-1:0] eoi_bcast_vec,
  output logic             err_illegal
);

  logic [NVEC-1:0] irr_q, isr_q, tmr_q;
  vec_t            tpr_q;

  logic irr_found, isr_found;
  vec_t irr_hi, isr_hi;

  // named internal events
  logic ack_fire, eoi_fire, req_low, req_ok, req_lvl_set;
  vec_t req_eff;
  cls_t isr_cls;

  vec_find #(.N(NVEC), .W(VEC_W)) u_find_irr (
    .bits(irr_q), .found(irr_found), .idx(irr_hi));
  vec_find #(.N(NVEC), .W(VEC_W)) u_find_isr (
    .bits(isr_q), .found(isr_found), .idx(isr_hi));

  assign isr_cls    = isr_found ? class_of(isr_hi) : '0;
  assign ppr        = calc_ppr(tpr_q, isr_cls);
  assign irq_valid  = enable && irr_found && above_floor(irr_hi, ppr);
  assign irq_vector = irr_hi;

  assign ack_fire   = ack && irq_valid;
  assign eoi_fire   = eoi_wr && isr_found;

  assign req_low     = req_vector < vec_t'(LEGAL_MIN);
  assign req_eff     = req_low ? err_vector : req_vector;
  assign req_ok      = req_valid && enable && !irr_q[req_eff];
  assign req_lvl_set = req_ok && req_level && !req_low;

  vec_bitmap #(.N(NVEC), .W(VEC_W)) u_irr (
    .clk(clk), .rst_n(rst_n),
    .set_en(req_ok),      .set_idx(req_eff),
    .clr_en(ack_fire),    .clr_idx(irr_hi),
    .q(irr_q));

  vec_bitmap #(.N(NVEC), .W(VEC_W)) u_isr (
    .clk(clk), .rst_n(rst_n),
    .set_en(ack_fire),    .set_idx(irr_hi),
    .clr_en(eoi_fire),    .clr_idx(isr_hi),
    .q(isr_q));

  vec_bitmap #(.N(NVEC), .W(VEC_W)) u_tmr (
    .clk(clk), .rst_n(rst_n),
    .set_en(req_lvl_set), .set_idx(req_eff),
    .clr_en(eoi_fire),    .clr_idx(isr_hi),
    .q(tmr_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tpr_q         <= '0;
      eoi_bcast     <= 1'b0;
      eoi_bcast_vec <= '0;
      err_illegal   <= 1'b0;
    end else begin
      if (tpr_wr) tpr_q <= tpr_wdata[VEC_W-1:0];
      eoi_bcast <= eoi_fire && tmr_q[isr_hi];
      if (eoi_fire) eoi_bcast_vec <= isr_hi;
      if (req_valid && enable && req_low) err_illegal <= 1'b1;
    end
  end

endmodule

// File: rtl/irq_prio_chk.sv
module irq_prio_chk
  import irq_prio_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            enable,
  input logic            irq_valid,
  input logic [VEC_W-1:0] irq_vector,
  input logic [VEC_W-1:0] ppr,
  input logic            eoi_bcast,
  input logic [VEC_W-1:0] eoi_bcast_vec,
  input logic            err_illegal,
  input logic [VEC_W-1:0] tpr_q,
  input logic [NVEC-1:0] irr_q,
  input logic [NVEC-1:0] isr_q,
  input logic            ack_fire,
  input logic            eoi_fire,
  input logic [VEC_W-1:0] isr_hi
);

  // R1
  ppr_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ppr >= tpr_q);

  // R1
  ppr_nibble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ppr != tpr_q) |-> (ppr[SUB_W-1:0] == '0));

  // R3
  offer_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> ({irq_vector[VEC_W-1 -: CLS_W], {SUB_W{1'b0}}} > ppr));

  // R3
  offer_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> irr_q[irq_vector]);

  // R4
  ack_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire |=> (isr_q[$past(irq_vector)] && !irr_q[$past(irq_vector)]));

  // R5
  eoi_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_fire |=> !isr_q[$past(isr_hi)]);

  // R6
  bcast_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_bcast |-> ($past(eoi_fire) && (eoi_bcast_vec == $past(isr_hi))));

  // R8
  illegal_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_illegal |=> err_illegal);

  // R9
  disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (irr_q == $past(irr_q)));

  // R9
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !irq_valid);

endmodule

bind irq_prio_unit irq_prio_chk u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable),
  .irq_valid(irq_valid), .irq_vector(irq_vector), .ppr(ppr),
  .eoi_bcast(eoi_bcast), .eoi_bcast_vec(eoi_bcast_vec),
  .err_illegal(err_illegal), .tpr_q(tpr_q),
  .irr_q(irr_q), .isr_q(isr_q),
  .ack_fire(ack_fire), .eoi_fire(eoi_fire), .isr_hi(isr_hi));

// File: tb/irq_prio_unit_test.sv
module irq_prio_unit_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable, req_valid, req_level, ack, eoi_wr, tpr_wr;
  logic [7:0] req_vector, err_vector;
  logic [31:0] tpr_wdata;
  logic irq_valid, eoi_bcast, err_illegal;
  logic [7:0] irq_vector, ppr, eoi_bcast_vec;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  irq_prio_unit uut (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .req_valid(req_valid), .req_vector(req_vector), .req_level(req_level),
    .err_vector(err_vector), .ack(ack), .eoi_wr(eoi_wr),
    .tpr_wr(tpr_wr), .tpr_wdata(tpr_wdata),
    .irq_valid(irq_valid), .irq_vector(irq_vector), .ppr(ppr),
    .eoi_bcast(eoi_bcast), .eoi_bcast_vec(eoi_bcast_vec),
    .err_illegal(err_illegal));

  // behavioural reference state
  bit m_pend[256];
  bit m_serv[256];
  bit m_lvl[256];
  int m_tpr = 0;
  bit m_err = 0;
  bit m_bc  = 0;
  int m_bcv = 0;

  function automatic int top_of(input bit a[256]);
    for (int i = 255; i >= 0; i--) if (a[i]) return i;
    return -1;
  endfunction

  function automatic int exp_ppr();
    int s = top_of(m_serv);
    int sc = (s < 0) ? 0 : s / 16;
    if (m_tpr / 16 >= sc) return m_tpr;
    return sc * 16;
  endfunction

  function automatic bit exp_valid();
    int p = top_of(m_pend);
    if (!enable || p < 0) return 0;
    return (p / 16) * 16 > exp_ppr();
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    check("R3/R9 irq_valid", int'(irq_valid), int'(exp_valid()));
    if (exp_valid()) check("R3 irq_vector", int'(irq_vector), top_of(m_pend));
    check("R1 ppr", int'(ppr), exp_ppr());
    check("R6 eoi_bcast", int'(eoi_bcast), int'(m_bc));
    if (m_bc) check("R6 eoi_bcast_vec", int'(eoi_bcast_vec), m_bcv);
    check("R8 err_illegal", int'(err_illegal), int'(m_err));
  endtask

  task automatic idle();
    req_valid = 0; req_level = 0; req_vector = 8'h00;
    ack = 0; eoi_wr = 0; tpr_wr = 0; tpr_wdata = 32'h0;
  endtask

  // apply current drives for one edge, advance the model, compare
  task automatic step();
    bit n_pend[256] = m_pend;
    bit n_serv[256] = m_serv;
    bit n_lvl[256]  = m_lvl;
    int off = top_of(m_pend);
    int ret = top_of(m_serv);
    bit offered = exp_valid();
    m_bc = 0;
    if (eoi_wr && ret >= 0) begin
      n_serv[ret] = 0;
      if (m_lvl[ret]) begin
        n_lvl[ret] = 0; m_bc = 1; m_bcv = ret;
      end
    end
    if (ack && offered) begin
      n_pend[off] = 0; n_serv[off] = 1;
    end
    if (req_valid && enable) begin
      int v = (req_vector < 16) ? int'(err_vector) : int'(req_vector);
      if (req_vector < 16) m_err = 1;
      if (!m_pend[v]) begin
        n_pend[v] = 1;
        if (req_level && req_vector >= 16) n_lvl[v] = 1;
      end
    end
    if (tpr_wr) m_tpr = int'(tpr_wdata) & 255;
    @(posedge clk);
    @(negedge clk);
    m_pend = n_pend; m_serv = n_serv; m_lvl = n_lvl;
    compare_all();
    idle();
  endtask

  task automatic request(input int v, input bit lvl);
    req_valid = 1; req_vector = 8'(v); req_level = lvl;
    step();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    enable = 1; err_vector = 8'hE3;
    idle();
    repeat (3) @(negedge clk);
    check("R1 reset ppr", int'(ppr), 0);
    check("R3 reset irq_valid", int'(irq_valid), 0);
    check("R6 reset eoi_bcast", int'(eoi_bcast), 0);
    rst_n = 1;
    @(negedge clk);

    request(8'h45, 0);
    check("R11 first request offered", int'(irq_vector), 8'h45);
    request(8'h82, 1);
    check("R3 highest offered", int'(irq_vector), 8'h82);
    request(8'h82, 0);                       // R7 duplicate dropped
    tpr_wr = 1; tpr_wdata = 32'h1234_5690; step();
    check("R2 tpr low byte", int'(ppr), 8'h90);
    check("R3 blocked by tpr", int'(irq_valid), 0);
    tpr_wr = 1; tpr_wdata = 32'h50; step();
    check("R3 unblocked", int'(irq_vector), 8'h82);
    ack = 1; step();
    check("R4 ppr from service class", int'(ppr), 8'h80);
    check("R4 lower vector held", int'(irq_valid), 0);
    eoi_wr = 1; step();
    check("R6 level strobe", int'(eoi_bcast), 1);
    check("R6 strobe vector", int'(eoi_bcast_vec), 8'h82);
    check("R5 ppr back to tpr", int'(ppr), 8'h50);
    tpr_wr = 1; tpr_wdata = 32'h0; step();
    check("R6 strobe one cycle", int'(eoi_bcast), 0);
    ack = 1; step();
    check("R4 ppr after ack 0x45", int'(ppr), 8'h40);
    request(8'h45, 0);
    check("R3 same class not offered", int'(irq_valid), 0);
    request(8'h60, 0);
    check("R11 new higher offered", int'(irq_vector), 8'h60);
    ack = 1; eoi_wr = 1; step();
    check("R10 ack+eoi ppr", int'(ppr), 8'h60);
    check("R10 edge retire no strobe", int'(eoi_bcast), 0);
    eoi_wr = 1; step();
    check("R5 retire 0x60", int'(irq_vector), 8'h45);
    eoi_wr = 1; step();
    check("R5 empty eoi no effect", int'(ppr), 0);
    ack = 0;
    enable = 0; request(8'h70, 0);
    check("R9 disabled no offer", int'(irq_valid), 0);
    enable = 1; step();
    check("R9 request ignored", int'(irq_vector), 8'h45);
    request(8'h05, 1);
    check("R8 error flag", int'(err_illegal), 1);
    check("R8 error vector raised", int'(irq_vector), 8'hE3);
    ack = 1; step();
    ack = 1; step();
    check("R4 ack without offer", int'(ppr), 8'hE0);
    eoi_wr = 1; step();
    check("R8 error vector edge", int'(eoi_bcast), 0);

    for (int n = 0; n < 3000; n++) begin
      int r = int'($urandom_range(99));
      enable = (r < 93);
      if ($urandom_range(99) < 40) begin
        req_valid = 1;
        req_vector = ($urandom_range(99) < 5) ? 8'($urandom_range(15))
                                              : 8'($urandom_range(255, 16));
        req_level = 1'($urandom_range(1));
      end
      ack    = ($urandom_range(99) < 35);
      eoi_wr = ($urandom_range(99) < 25);
      if ($urandom_range(99) < 5) begin
        tpr_wr = 1; tpr_wdata = $urandom;
      end
      step();
    end
    enable = 1;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule